// File: doc/BRIEF.md
# Paired-Channel Interrupt Priority Arbiter

This block selects one winner among nine interrupt channels. The channels are numbered 0 to 8 and named E0, E1, F0, F1, G0, G1, H0, H1 and I0. Each channel has a pending flag. A one-cycle trigger pulse sets the flag. Software can also set it through the register port, which raises a software interrupt. An acknowledge clears the flag of the current winner.

Channels are grouped in pairs: E, F, G, H and I. Each pair has a two-bit priority field that software programs. A channel's full level is three bits: the pair field on top, with the channel's parity (0 for even, 1 for odd) as the least significant bit. A lower level wins. When levels tie, the lower channel number wins.

A start pulse begins an arbitration cycle. On that pulse the block latches the four-bit code of the best pending channel and holds it until the next start. The block presents an 8-bit vector made of three software-written upper bits, the latched code, and a zero bit. It also raises an interrupt request while any flag is pending.

Top module: `irq_pair_arbiter`

## Requirements
- R1: After reset, these values hold:
  - all pending flags are 0;
  - the vector's bits 4:0 read 11110, so the latched code is 1111;
  - both priority registers (addresses 3 and 4) read FFh;
  - the interrupt request is low.
- R2: A trigger pulse on channel n sets its pending flag. The flag shows at the next clock edge. Address 0 returns channels 0..7 in bits 0..7. Address 1 returns channel 8 (I0) in bit 0, and its other bits read 0.
- R3: A write to address 0 or 1 sets each pending flag whose data bit is 1. A data bit of 0 leaves its flag unchanged.
- R4: The start pulse latches the channel code of the pending channel with the numerically lowest level. The code of channel n is n. The level is {pair field, n mod 2}. Pair fields are:
  - address 3: E in bits 1:0, F in bits 3:2, G in bits 5:4, H in bits 7:6;
  - address 4: I in bits 1:0.
- R5: Among pending channels with equal three-bit levels, the lowest channel code is latched.
- R6: The latched code changes only on a start pulse. A better request that arrives after a start does not change it; it is latched at the next start.
- R7: A start pulse while no flag is pending leaves the latched code unchanged.
- R8: An acknowledge clears only the pending flag of the latched channel. A trigger on that channel in the same cycle keeps its flag set.
- R9: The vector output equals {V[2:0], code[3:0], 0}. Address 2 reads the same value. A write to address 2 loads V from data bits 7:5 and does not change the code.
- R10: The priority registers at addresses 3 and 4 can be written and read back. At address 4, bits 7:2 always read 1.
- R11: The interrupt request is registered. It goes high one cycle after any flag is pending. It goes low one cycle after the last flag clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig | input | 9 | Per-channel trigger pulses |
| cycle_start | input | 1 | Start of an arbitration cycle; latches the winner |
| ack | input | 1 | Acknowledge; clears the latched winner's flag |
| we | input | 1 | Register write enable |
| addr | input | 3 | Register address (read and write) |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Registered read data for addr |
| vector | output | 8 | {V, winner code, 0} |
| irq | output | 1 | Interrupt request, high while any flag is pending |

## Verification
Single-channel triggers on different channels map each channel to its bit, checking R2. Three cases show that the priority field takes precedence over channel order:
- pending sets with different pair fields;
- the two members of one pair, which must split by parity;
- I0 against an odd E channel.

Cross-pair ties with equal levels show that the lower channel code breaks the tie. Starts interleaved with late higher-priority triggers, and a start with nothing pending, separate a frozen winner from one that follows the inputs. An acknowledge that coincides with a trigger separates set-dominant from clear-dominant behaviour.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int DEF_NCH    = 9;
  localparam int DEF_DATA_W = 8;
  localparam int DEF_CODE_W = 4;
  localparam int DEF_FLD_W  = 2;
  localparam int DEF_ADDR_W = 3;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int NCH    = irq_arb_pkg::DEF_NCH,
  parameter int CODE_W = irq_arb_pkg::DEF_CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    trig,
  input  logic [NCH-1:0]    sw_set,
  input  logic              ack,
  input  logic [CODE_W-1:0] ack_code,
  output logic [NCH-1:0]    pend
);
  logic [NCH-1:0] clr;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign clr[i] = ack && (ack_code == CODE_W'(i));

    // Set wins over clear in the same cycle.
    always_ff @(posedge clk) begin
      if (rst) pend[i] <= 1'b0;
      else     pend[i] <= (pend[i] && !clr[i]) || trig[i] || sw_set[i];
    end

    assert_set_holds_R8: assert property (@(posedge clk) disable iff (rst)
      (trig[i] || sw_set[i]) |=> pend[i]);
    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (rst)
      (ack && ack_code == CODE_W'(i) && !trig[i] && !sw_set[i]) |=> !pend[i]);
  end
endmodule

// File: rtl/irq_prio_tree.sv
module irq_prio_tree #(
  parameter int NCH    = irq_arb_pkg::DEF_NCH,
  parameter int CODE_W = irq_arb_pkg::DEF_CODE_W,
  parameter int FLD_W  = irq_arb_pkg::DEF_FLD_W,
  localparam int PAIRS = (NCH + 1) / 2,
  localparam int LVL_W = FLD_W + 1
) (
  input  logic [NCH-1:0]         pend,
  input  logic [PAIRS*FLD_W-1:0] fld,
  output logic                   any,
  output logic [CODE_W-1:0]      best
);
  logic [LVL_W-1:0]  lvl    [NCH];
  logic [LVL_W-1:0]  lvl_c  [NCH+1];
  logic [CODE_W-1:0] code_c [NCH+1];
  logic              hit_c  [NCH+1];
  logic [NCH-1:0]    take;

  assign lvl_c[0]  = '1;
  assign code_c[0] = '0;
  assign hit_c[0]  = 1'b0;

  // Linear chain: strict less-than keeps the earlier (lower) code on a tie.
  for (genvar i = 0; i < NCH; i++) begin : g_stage
    assign lvl[i]       = {fld[(i/2)*FLD_W +: FLD_W], (i % 2 == 1)};
    assign take[i]      = pend[i] && (!hit_c[i] || (lvl[i] < lvl_c[i]));
    assign hit_c[i+1]   = hit_c[i] || pend[i];
    assign lvl_c[i+1]   = take[i] ? lvl[i] : lvl_c[i];
    assign code_c[i+1]  = take[i] ? CODE_W'(i) : code_c[i];

    always_comb begin
      if (pend[i] && hit_c[NCH]) begin
        assert_no_better_R4: assert (!(lvl[i] < lvl_c[NCH]));
        assert_tie_low_code_R5: assert (!((lvl[i] == lvl_c[NCH]) && (CODE_W'(i) < code_c[NCH])));
      end
    end
  end

  assign any  = hit_c[NCH];
  assign best = code_c[NCH];

  always_comb begin
    if (hit_c[NCH]) assert_winner_pending_R4: assert (pend[code_c[NCH]]);
  end
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile #(
  parameter int NCH    = irq_arb_pkg::DEF_NCH,
  parameter int DATA_W = irq_arb_pkg::DEF_DATA_W,
  parameter int CODE_W = irq_arb_pkg::DEF_CODE_W,
  parameter int FLD_W  = irq_arb_pkg::DEF_FLD_W,
  parameter int ADDR_W = irq_arb_pkg::DEF_ADDR_W,
  localparam int PAIRS     = (NCH + 1) / 2,
  localparam int NPREG     = (NCH + DATA_W - 1) / DATA_W,
  localparam int FPR       = DATA_W / FLD_W,
  localparam int NPRIO     = (PAIRS + FPR - 1) / FPR,
  localparam int VEC_ADDR  = NPREG,
  localparam int PRIO_BASE = NPREG + 1,
  localparam int VH_W      = DATA_W - CODE_W - 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      wdata,
  input  logic [NCH-1:0]         pend,
  input  logic [CODE_W-1:0]      win,
  output logic [NCH-1:0]         sw_set,
  output logic [PAIRS*FLD_W-1:0] fld_flat,
  output logic [VH_W-1:0]        vhi,
  output logic [DATA_W-1:0]      rdata
);
  logic [FLD_W-1:0]  fld [PAIRS];
  logic [DATA_W-1:0] rd_next;

  for (genvar c = 0; c < NCH; c++) begin : g_sw
    assign sw_set[c] = we && (addr == ADDR_W'(c / DATA_W)) && wdata[c % DATA_W];
  end

  for (genvar p = 0; p < PAIRS; p++) begin : g_fld
    assign fld_flat[p*FLD_W +: FLD_W] = fld[p];
    always_ff @(posedge clk) begin
      if (rst)
        fld[p] <= '1;
      else if (we && addr == ADDR_W'(PRIO_BASE + p / FPR))
        fld[p] <= wdata[(p % FPR)*FLD_W +: FLD_W];
    end
  end

  // Upper vector bits are deliberately left out of reset.
  always_ff @(posedge clk) begin
    if (we && addr == ADDR_W'(VEC_ADDR)) vhi <= wdata[DATA_W-1 -: VH_W];
  end

  always_comb begin
    rd_next = '0;
    for (int k = 0; k < NPREG; k++) begin
      if (addr == ADDR_W'(k)) begin
        for (int b = 0; b < DATA_W; b++) begin
          if (k*DATA_W + b < NCH) rd_next[b] = pend[k*DATA_W + b];
        end
      end
    end
    if (addr == ADDR_W'(VEC_ADDR)) rd_next = {vhi, win, 1'b0};
    for (int k = 0; k < NPRIO; k++) begin
      if (addr == ADDR_W'(PRIO_BASE + k)) begin
        rd_next = '1;
        for (int f = 0; f < FPR; f++) begin
          if (k*FPR + f < PAIRS) rd_next[f*FLD_W +: FLD_W] = fld[k*FPR + f];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end
endmodule

// File: rtl/irq_pair_arbiter.sv
module irq_pair_arbiter #(
  parameter int NCH    = irq_arb_pkg::DEF_NCH,
  parameter int DATA_W = irq_arb_pkg::DEF_DATA_W,
  parameter int CODE_W = irq_arb_pkg::DEF_CODE_W,
  parameter int FLD_W  = irq_arb_pkg::DEF_FLD_W,
  parameter int ADDR_W = irq_arb_pkg::DEF_ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    trig,
  input  logic              cycle_start,
  input  logic              ack,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] vector,
  output logic              irq
);
  localparam int PAIRS = (NCH + 1) / 2;
  localparam int VH_W  = DATA_W - CODE_W - 1;

  logic [NCH-1:0]         pend;
  logic [NCH-1:0]         sw_set;
  logic [PAIRS*FLD_W-1:0] fld_flat;
  logic [VH_W-1:0]        vhi;
  logic                   any;
  logic [CODE_W-1:0]      best;
  logic [CODE_W-1:0]      win;

  irq_pend_bank #(.NCH(NCH), .CODE_W(CODE_W)) u_bank (
    .clk(clk), .rst(rst), .trig(trig), .sw_set(sw_set),
    .ack(ack), .ack_code(win), .pend(pend));

  irq_prio_tree #(.NCH(NCH), .CODE_W(CODE_W), .FLD_W(FLD_W)) u_tree (
    .pend(pend), .fld(fld_flat), .any(any), .best(best));

  irq_regfile #(.NCH(NCH), .DATA_W(DATA_W), .CODE_W(CODE_W), .FLD_W(FLD_W),
                .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .we(we), .addr(addr), .wdata(wdata),
    .pend(pend), .win(win), .sw_set(sw_set), .fld_flat(fld_flat),
    .vhi(vhi), .rdata(rdata));

  always_ff @(posedge clk) begin
    if (rst)                     win <= '1;
    else if (cycle_start && any) win <= best;
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |pend;
  end

  assign vector = {vhi, win, 1'b0};

  assert_win_frozen_R6: assert property (@(posedge clk) disable iff (rst)
    !cycle_start |=> $stable(win));
  assert_idle_start_R7: assert property (@(posedge clk) disable iff (rst)
    (cycle_start && pend == '0) |=> $stable(win));
  assert_irq_rise_R11: assert property (@(posedge clk) disable iff (rst)
    (pend != '0) |=> irq);
  assert_irq_fall_R11: assert property (@(posedge clk) disable iff (rst)
    (pend == '0) |=> !irq);
endmodule

// File: tb/irq_pair_arbiter_test.sv
module irq_pair_arbiter_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [8:0] trig = '0;
  logic       cycle_start = 1'b0;
  logic       ack = 1'b0;
  logic       we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] vector;
  logic       irq;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_pair_arbiter uut (
    .clk(clk), .rst(rst), .trig(trig), .cycle_start(cycle_start), .ack(ack),
    .we(we), .addr(addr), .wdata(wdata), .rdata(rdata), .vector(vector), .irq(irq));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; trig = '0; cycle_start = 0; ack = 0; we = 0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic pulse_trig(input logic [8:0] t);
    @(negedge clk); trig = t;
    @(negedge clk); trig = '0;
  endtask

  task automatic start();
    @(negedge clk); cycle_start = 1'b1;
    @(negedge clk); cycle_start = 1'b0;
  endtask

  task automatic do_ack(input logic [8:0] t);
    @(negedge clk); ack = 1'b1; trig = t;
    @(negedge clk); ack = 1'b0; trig = '0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    do_reset();
    rd(3'd0, d); chk("R1 pend low", d, 8'h00);
    rd(3'd1, d); chk("R1 pend high", d, 8'h00);
    chk("R1 vector low", {3'b0, vector[4:0]}, 8'h1E);
    rd(3'd3, d); chk("R1 prio EH", d, 8'hFF);
    rd(3'd4, d); chk("R1 prio I", d, 8'hFF);
    chk("R1 irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_trig_layout();
    logic [7:0] d;
    do_reset();
    pulse_trig(9'h020);
    rd(3'd0, d); chk("R2 G1 bit5", d, 8'h20);
    rd(3'd1, d); chk("R2 I0 not set", d, 8'h00);
    pulse_trig(9'h100);
    rd(3'd1, d); chk("R2 I0 bit0", d, 8'h01);
    chk("R11 irq high", {7'b0, irq}, 8'h01);
  endtask

  task automatic t_sw();
    logic [7:0] d;
    do_reset();
    wr(3'd0, 8'h03);
    rd(3'd0, d); chk("R3 sw set", d, 8'h03);
    wr(3'd0, 8'h00);
    rd(3'd0, d); chk("R3 zero no effect", d, 8'h03);
    wr(3'd1, 8'h01);
    rd(3'd1, d); chk("R3 sw set I0", d, 8'h01);
  endtask

  task automatic t_prio();
    do_reset();
    wr(3'd3, 8'hDB);          // E=11 F=10 G=01 H=11
    pulse_trig(9'h069);       // E0, F1, G1, H0
    start();
    chk("R4 field order", {4'b0, vector[4:1]}, 8'h05);
    do_reset();
    wr(3'd3, 8'h00);
    pulse_trig(9'h030);       // G0, G1
    start();
    chk("R4 parity split", {4'b0, vector[4:1]}, 8'h04);
    do_reset();
    pulse_trig(9'h102);       // E1 (111), I0 (110)
    start();
    chk("R4 I0 over E1", {4'b0, vector[4:1]}, 8'h08);
  endtask

  task automatic t_tie();
    do_reset();
    pulse_trig(9'h044);       // F0, H0 both 110
    start();
    chk("R5 tie F0", {4'b0, vector[4:1]}, 8'h02);
    do_reset();
    pulse_trig(9'h140);       // H0, I0 both 110
    start();
    chk("R5 tie H0", {4'b0, vector[4:1]}, 8'h06);
  endtask

  task automatic t_freeze();
    do_reset();
    start();
    chk("R7 idle start", {4'b0, vector[4:1]}, 8'h0F);
    pulse_trig(9'h002);       // E1
    start();
    chk("R6 first latch", {4'b0, vector[4:1]}, 8'h01);
    pulse_trig(9'h001);       // E0 better, arrives late
    @(negedge clk); @(negedge clk);
    chk("R6 frozen", {4'b0, vector[4:1]}, 8'h01);
    start();
    chk("R6 next cycle", {4'b0, vector[4:1]}, 8'h00);
  endtask

  task automatic t_ack();
    logic [7:0] d;
    do_reset();
    wr(3'd0, 8'h03);
    start();
    do_ack(9'h000);
    rd(3'd0, d); chk("R8 clears winner only", d, 8'h02);
    start();
    chk("R8 new winner", {4'b0, vector[4:1]}, 8'h01);
    do_ack(9'h002);
    rd(3'd0, d); chk("R8 set beats clear", d, 8'h02);
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    chk("R11 irq still high", {7'b0, irq}, 8'h01);
    @(negedge clk);
    chk("R11 irq low", {7'b0, irq}, 8'h00);
    rd(3'd0, d); chk("R8 all clear", d, 8'h00);
  endtask

  task automatic t_vec();
    logic [7:0] d;
    do_reset();
    wr(3'd2, 8'hA0);
    chk("R9 vector", vector, 8'hBE);
    rd(3'd2, d); chk("R9 readback", d, 8'hBE);
    pulse_trig(9'h008);
    start();
    chk("R9 code in vector", vector, 8'hA6);
    wr(3'd2, 8'h5F);
    chk("R9 code kept", vector, 8'h46);
  endtask

  task automatic t_prio_rw();
    logic [7:0] d;
    do_reset();
    wr(3'd3, 8'h5A);
    rd(3'd3, d); chk("R10 prio EH rw", d, 8'h5A);
    wr(3'd4, 8'h00);
    rd(3'd4, d); chk("R10 prio I rw", d, 8'hFC);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_trig_layout();
        t_sw();
        t_prio();
        t_tie();
        t_freeze();
        t_ack();
        t_vec();
        t_prio_rw();
      end
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule